// File: doc/BRIEF.md
# Fault Status and Alert Manager

This block gathers the protection events of a hot-swap power path (input overcurrent or power-limit timeout, circuit-breaker trip, input undervoltage, input overvoltage, pass-device over-temperature, a shorted pass device) and records each one as a sticky bit. One event can show up in several status views at the same time: a summary word, an input word, a temperature word, an "other" word, a vendor word and a combined diagnostic word. An active-low alert line is pulled low while any recorded source that is not masked remains set.

Over-temperature is detected by comparing an 8-bit temperature reading in °C against a writable limit whose reset value is 256, which no 8-bit reading can reach, so the check stays inert until software lowers the limit. A shorted pass device is detected when the sense-resistor voltage exceeds 4 mV while the gate drive is off. After reset a configuration-default flag is set and holds alert low until software issues a clear command. A simple address/data register port takes the place of the management bus.

Top module: `fault_alert_mgr`

## Requirements
- R1: After reset the only recorded source is the configuration-default flag, the mask is zero, the temperature limit (address 7) reads 256 and alert_n is 0; with pwr_good low the summary word (address 0) reads 0x0038, the vendor word (address 4) 0x0004 and the diagnostic word (address 5) 0x0040.
- R2: An overcurrent timeout pulse sets input word bit 0, summary bit 0 and diagnostic bit 0.
- R3: A breaker trip sets "other" word (address 3) bit 0, vendor word bit 0, diagnostic bit 4 and summary bits 2 and 3.
- R4: Undervoltage sets input word bit 1 and diagnostic bit 1; overvoltage sets input word bit 2 and diagnostic bit 2.
- R5: When temp_c is greater than or equal to the limit, temperature word (address 2) bit 0, diagnostic bit 3 and summary bit 1 are set; with the reset limit no reading sets them.
- R6: When gate_on is 0 and sense_mv is greater than 4, vendor bit 1 and diagnostic bit 5 are set; a reading of exactly 4, or any reading while gate_on is 1, sets nothing.
- R7: Every recorded bit stays set after its condition has gone away.
- R8: A write to address 15 clears every recorded bit whose condition is absent in that cycle; a bit whose condition is still present stays set.
- R9: The configuration-default flag (vendor bit 2, diagnostic bit 6, summary bit 5) is set only by reset and cleared only by the clear command.
- R10: The mask register (address 6) holds one bit per source in diagnostic bit order 0 to 6, 1 meaning masked; alert_n is 0 exactly when some recorded bit with a zero mask bit is set.
- R11: Power-good is reported live: diagnostic bit 7 equals pwr_good and summary bit 4 equals its inverse.
- R12: Writes to the status addresses 0 to 5 leave the recorded state unchanged.
- R13: A limit write with any data bit above bit 8 set stores 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_oc_tmo | input | 1 | Overcurrent or power-limit fault timeout |
| evt_cb | input | 1 | Circuit-breaker trip |
| lvl_uv | input | 1 | Input below undervoltage threshold |
| lvl_ov | input | 1 | Input above overvoltage threshold |
| temp_c | input | 8 | Pass-device temperature in °C |
| sense_mv | input | 8 | Sense-resistor voltage in mV |
| gate_on | input | 1 | Gate drive commanded on |
| pwr_good | input | 1 | Output power-good level |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| alert_n | output | 1 | Active-low alert |

## Verification
The hardest situation to reach is a clear command landing in the very cycle a fault condition is still present, since the bit must survive while its neighbours drop. The stimulus holds undervoltage asserted across a clear write, checks the bit is still recorded, then releases it and clears again. Masked alerts are reached by setting a mask bit first, raising that source, and observing alert_n stay high while the diagnostic word still shows the bit.

// File: rtl/fam_pkg.sv
package fam_pkg;
  localparam int DW  = 16;
  localparam int AW  = 4;
  localparam int NEV = 7;

  localparam int E_OC    = 0;
  localparam int E_UV    = 1;
  localparam int E_OV    = 2;
  localparam int E_OT    = 3;
  localparam int E_CB    = 4;
  localparam int E_SHORT = 5;
  localparam int E_CFG   = 6;

  localparam logic [AW-1:0] A_MAIN  = 4'h0;
  localparam logic [AW-1:0] A_INP   = 4'h1;
  localparam logic [AW-1:0] A_TEMP  = 4'h2;
  localparam logic [AW-1:0] A_OTHER = 4'h3;
  localparam logic [AW-1:0] A_VEND  = 4'h4;
  localparam logic [AW-1:0] A_DIAG  = 4'h5;
  localparam logic [AW-1:0] A_MASK  = 4'h6;
  localparam logic [AW-1:0] A_TLIM  = 4'h7;
  localparam logic [AW-1:0] A_CLR   = 4'hF;

  function automatic logic [DW-1:0] view_main(logic [NEV-1:0] s, logic pg);
    logic [DW-1:0] v;
    v = '0;
    v[0] = s[E_OC] | s[E_UV] | s[E_OV];
    v[1] = s[E_OT];
    v[2] = s[E_CB];
    v[3] = s[E_CB] | s[E_SHORT] | s[E_CFG];
    v[4] = ~pg;
    v[5] = s[E_CFG];
    return v;
  endfunction

  function automatic logic [DW-1:0] view_input(logic [NEV-1:0] s);
    logic [DW-1:0] v;
    v = '0;
    v[0] = s[E_OC];
    v[1] = s[E_UV];
    v[2] = s[E_OV];
    return v;
  endfunction

  function automatic logic [DW-1:0] view_temp(logic [NEV-1:0] s);
    logic [DW-1:0] v;
    v = '0;
    v[0] = s[E_OT];
    return v;
  endfunction

  function automatic logic [DW-1:0] view_other(logic [NEV-1:0] s);
    logic [DW-1:0] v;
    v = '0;
    v[0] = s[E_CB];
    return v;
  endfunction

  function automatic logic [DW-1:0] view_vendor(logic [NEV-1:0] s);
    logic [DW-1:0] v;
    v = '0;
    v[0] = s[E_CB];
    v[1] = s[E_SHORT];
    v[2] = s[E_CFG];
    return v;
  endfunction

  function automatic logic [DW-1:0] view_diag(logic [NEV-1:0] s, logic pg);
    logic [DW-1:0] v;
    v = '0;
    v[NEV-1:0] = s;
    v[NEV]     = pg;
    return v;
  endfunction

  function automatic logic alert_level(logic [NEV-1:0] s, logic [NEV-1:0] m);
    return ~|(s & ~m);
  endfunction
endpackage

// File: rtl/fam_event_detect.sv
module fam_event_detect #(
  parameter int TEMP_W   = 8,
  parameter int SENSE_W  = 8,
  parameter int SHORT_MV = 4,
  localparam int TLIM_W  = TEMP_W + 1
) (
  input  logic                    evt_oc_tmo,
  input  logic                    evt_cb,
  input  logic                    lvl_uv,
  input  logic                    lvl_ov,
  input  logic [TEMP_W-1:0]       temp_c,
  input  logic [SENSE_W-1:0]      sense_mv,
  input  logic                    gate_on,
  input  logic [TLIM_W-1:0]       ot_limit,
  output logic [fam_pkg::NEV-1:0] raw_evt
);
  import fam_pkg::*;

  logic ot_hit;
  logic short_hit;

  assign ot_hit    = ({1'b0, temp_c} >= ot_limit);
  assign short_hit = !gate_on && (sense_mv > SENSE_W'(SHORT_MV));

  always_comb begin
    raw_evt          = '0;
    raw_evt[E_OC]    = evt_oc_tmo;
    raw_evt[E_UV]    = lvl_uv;
    raw_evt[E_OV]    = lvl_ov;
    raw_evt[E_OT]    = ot_hit;
    raw_evt[E_CB]    = evt_cb;
    raw_evt[E_SHORT] = short_hit;
    raw_evt[E_CFG]   = 1'b0;
  end
endmodule

// File: rtl/fam_sticky_bank.sv
module fam_sticky_bank #(
  parameter int                 N       = 7,
  parameter logic [N-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_evt,
  input  logic         clr_fire,
  output logic [N-1:0] sticky
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky[i] <= RST_VAL[i];
      else        sticky[i] <= raw_evt[i] | (sticky[i] & ~clr_fire);
    end
  end
endmodule

// File: rtl/fam_regs.sv
module fam_regs #(
  parameter int  TLIM_W   = 9,
  parameter int  TLIM_RST = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [fam_pkg::AW-1:0]  reg_addr,
  input  logic                    reg_we,
  input  logic [fam_pkg::DW-1:0]  reg_wdata,
  input  logic [fam_pkg::NEV-1:0] sticky,
  input  logic                    pwr_good,
  output logic [fam_pkg::NEV-1:0] mask_q,
  output logic [TLIM_W-1:0]       lim_q,
  output logic                    clr_fire,
  output logic [fam_pkg::DW-1:0]  reg_rdata
);
  import fam_pkg::*;

  logic              wr_mask;
  logic              wr_lim;
  logic              lim_over;
  logic [TLIM_W-1:0] lim_next;

  assign wr_mask  = reg_we && (reg_addr == A_MASK);
  assign wr_lim   = reg_we && (reg_addr == A_TLIM);
  assign clr_fire = reg_we && (reg_addr == A_CLR);
  assign lim_over = |reg_wdata[DW-1:TLIM_W];
  assign lim_next = lim_over ? {TLIM_W{1'b1}} : reg_wdata[TLIM_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      lim_q  <= TLIM_W'(TLIM_RST);
    end else begin
      if (wr_mask) mask_q <= reg_wdata[NEV-1:0];
      if (wr_lim)  lim_q  <= lim_next;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_MAIN:  reg_rdata = view_main(sticky, pwr_good);
      A_INP:   reg_rdata = view_input(sticky);
      A_TEMP:  reg_rdata = view_temp(sticky);
      A_OTHER: reg_rdata = view_other(sticky);
      A_VEND:  reg_rdata = view_vendor(sticky);
      A_DIAG:  reg_rdata = view_diag(sticky, pwr_good);
      A_MASK:  reg_rdata = DW'(mask_q);
      A_TLIM:  reg_rdata = DW'(lim_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fault_alert_mgr.sv
module fault_alert_mgr #(
  parameter int TEMP_W   = 8,
  parameter int SENSE_W  = 8,
  parameter int SHORT_MV = 4,
  parameter int TLIM_RST = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   evt_oc_tmo,
  input  logic                   evt_cb,
  input  logic                   lvl_uv,
  input  logic                   lvl_ov,
  input  logic [TEMP_W-1:0]      temp_c,
  input  logic [SENSE_W-1:0]     sense_mv,
  input  logic                   gate_on,
  input  logic                   pwr_good,
  input  logic [fam_pkg::AW-1:0] reg_addr,
  input  logic                   reg_we,
  input  logic [fam_pkg::DW-1:0] reg_wdata,
  output logic [fam_pkg::DW-1:0] reg_rdata,
  output logic                   alert_n
);
  import fam_pkg::*;

  localparam int            TLIM_W  = TEMP_W + 1;
  localparam logic [NEV-1:0] STK_RST = NEV'(1) << E_CFG;

  logic [NEV-1:0]    raw_evt;
  logic [NEV-1:0]    sticky_q;
  logic [NEV-1:0]    mask_q;
  logic [TLIM_W-1:0] lim_q;
  logic              clr_fire;

  fam_event_detect #(
    .TEMP_W(TEMP_W), .SENSE_W(SENSE_W), .SHORT_MV(SHORT_MV)
  ) u_det (
    .evt_oc_tmo(evt_oc_tmo), .evt_cb(evt_cb), .lvl_uv(lvl_uv), .lvl_ov(lvl_ov),
    .temp_c(temp_c), .sense_mv(sense_mv), .gate_on(gate_on),
    .ot_limit(lim_q), .raw_evt(raw_evt)
  );

  fam_sticky_bank #(.N(NEV), .RST_VAL(STK_RST)) u_bank (
    .clk(clk), .rst_n(rst_n), .raw_evt(raw_evt), .clr_fire(clr_fire),
    .sticky(sticky_q)
  );

  fam_regs #(.TLIM_W(TLIM_W), .TLIM_RST(TLIM_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .sticky(sticky_q), .pwr_good(pwr_good),
    .mask_q(mask_q), .lim_q(lim_q), .clr_fire(clr_fire), .reg_rdata(reg_rdata)
  );

  assign alert_n = alert_level(sticky_q, mask_q);
endmodule

// File: rtl/fam_checker.sv
module fam_checker (
  input logic                    clk,
  input logic                    rst_n,
  input logic [fam_pkg::NEV-1:0] sticky,
  input logic [fam_pkg::NEV-1:0] raw_evt,
  input logic [fam_pkg::NEV-1:0] mask_q,
  input logic                    clr_fire,
  input logic                    gate_on,
  input logic                    alert_n
);
  import fam_pkg::*;

  // R2 R3 R4: any present condition is recorded on the next edge
  a_r2_event_records: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky & $past(raw_evt)) == $past(raw_evt)));

  // R7: without a clear nothing recorded is lost
  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_fire |=> ((sticky & $past(sticky)) == $past(sticky)));

  // R8: a clear leaves only bits whose condition was present
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> ((sticky & ~$past(raw_evt)) == '0));

  // R9: the configuration flag only falls after a clear
  a_r9_cfg_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky[E_CFG]) |-> $past(clr_fire));

  // R6: no short is reported while the gate is driven
  a_r6_short_gated: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> !raw_evt[E_SHORT]);

  // R10: everything masked keeps alert released
  a_r10_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> alert_n);
endmodule

bind fault_alert_mgr fam_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sticky(sticky_q), .raw_evt(raw_evt),
  .mask_q(mask_q), .clr_fire(clr_fire), .gate_on(gate_on), .alert_n(alert_n)
);

// File: tb/fault_alert_mgr_test.sv
module fault_alert_mgr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_oc_tmo = 1'b0, evt_cb = 1'b0, lvl_uv = 1'b0, lvl_ov = 1'b0;
  logic [7:0]  temp_c = 8'd0, sense_mv = 8'd0;
  logic        gate_on = 1'b1, pwr_good = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        alert_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  fault_alert_mgr uut (
    .clk(clk), .rst_n(rst_n), .evt_oc_tmo(evt_oc_tmo), .evt_cb(evt_cb),
    .lvl_uv(lvl_uv), .lvl_ov(lvl_ov), .temp_c(temp_c), .sense_mv(sense_mv),
    .gate_on(gate_on), .pwr_good(pwr_good), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alert_n(alert_n)
  );

  // {oc, cb, uv, ov, temp[8], sense[8], gate, pg, expected diag[8]}
  localparam logic [29:0] VEC [10] = '{
    {1'b1,1'b0,1'b0,1'b0,8'd0,  8'd0,1'b1,1'b1,8'h81},
    {1'b0,1'b1,1'b0,1'b0,8'd0,  8'd0,1'b1,1'b1,8'h90},
    {1'b0,1'b0,1'b1,1'b0,8'd0,  8'd0,1'b1,1'b0,8'h02},
    {1'b0,1'b0,1'b0,1'b1,8'd0,  8'd0,1'b1,1'b1,8'h84},
    {1'b0,1'b0,1'b0,1'b0,8'd100,8'd0,1'b1,1'b1,8'h88},
    {1'b0,1'b0,1'b0,1'b0,8'd99, 8'd0,1'b1,1'b1,8'h80},
    {1'b0,1'b0,1'b0,1'b0,8'd0,  8'd5,1'b0,1'b1,8'hA0},
    {1'b0,1'b0,1'b0,1'b0,8'd0,  8'd4,1'b0,1'b1,8'h80},
    {1'b0,1'b0,1'b0,1'b0,8'd0,  8'd9,1'b1,1'b1,8'h80},
    {1'b1,1'b1,1'b1,1'b0,8'd0,  8'd0,1'b1,1'b0,8'h13}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic idle_inputs();
    evt_oc_tmo = 1'b0; evt_cb = 1'b0; lvl_uv = 1'b0; lvl_ov = 1'b0;
    temp_c = 8'd0; sense_mv = 8'd0; gate_on = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, v); check("R1 main", v, 16'h0038);
    rd(4'h4, v); check("R1 vendor", v, 16'h0004);
    rd(4'h5, v); check("R1 diag", v, 16'h0040);
    rd(4'h6, v); check("R1 mask", v, 16'h0000);
    rd(4'h7, v); check("R1 limit", v, 16'd256);
    check("R1 alert", {15'd0, alert_n}, 16'd0);

    // R5 default limit cannot be reached
    temp_c = 8'd255; tick(); temp_c = 8'd0;
    rd(4'h2, v); check("R5 default limit inert", v, 16'h0000);

    // R9 clear drops config flag
    wr(4'hF, 16'h0);
    rd(4'h5, v); check("R9 cfg cleared", v, 16'h0000);
    check("R9 alert released", {15'd0, alert_n}, 16'd1);

    // R2 multi-view
    pwr_good = 1'b1;
    evt_oc_tmo = 1'b1; tick(); evt_oc_tmo = 1'b0;
    rd(4'h1, v); check("R2 input word", v, 16'h0001);
    rd(4'h0, v); check("R2 main word", v, 16'h0001);
    wr(4'hF, 16'h0);

    // R3 multi-view
    evt_cb = 1'b1; tick(); evt_cb = 1'b0;
    rd(4'h3, v); check("R3 other word", v, 16'h0001);
    rd(4'h4, v); check("R3 vendor word", v, 16'h0001);
    rd(4'h0, v); check("R3 main word", v, 16'h000C);

    // R12 writes to status views ignored
    wr(4'h5, 16'h0000); wr(4'h3, 16'h0000);
    rd(4'h5, v); check("R12 diag unchanged", v, 16'h0090);
    wr(4'hF, 16'h0);

    wr(4'h7, 16'd100);
    // Table walk: R2 R4 R5 R6 R7 R10 R11
    for (int i = 0; i < 10; i++) begin
      {evt_oc_tmo, evt_cb, lvl_uv, lvl_ov, temp_c, sense_mv, gate_on, pwr_good} = VEC[i][29:8];
      tick();
      idle_inputs();
      rd(4'h5, v); check("R4 R5 R6 R7 R11 diag vector", v, {8'h00, VEC[i][7:0]});
      check("R10 alert vector", {15'd0, alert_n}, {15'd0, (VEC[i][6:0] == 7'd0)});
      wr(4'hF, 16'h0);
      rd(4'h5, v); check("R8 cleared vector", v, {8'h00, VEC[i][7], 7'd0});
    end

    // R8 clear while condition present
    pwr_good = 1'b1;
    lvl_uv = 1'b1; tick();
    wr(4'hF, 16'h0);
    rd(4'h1, v); check("R8 live bit survives clear", v, 16'h0002);
    lvl_uv = 1'b0;
    wr(4'hF, 16'h0);
    rd(4'h1, v); check("R8 bit gone after release", v, 16'h0000);

    // R10 mask
    wr(4'h6, 16'h0001);
    evt_oc_tmo = 1'b1; tick(); evt_oc_tmo = 1'b0;
    check("R10 masked alert high", {15'd0, alert_n}, 16'd1);
    rd(4'h5, v); check("R10 masked bit recorded", v, 16'h0081);
    wr(4'h6, 16'h0000);
    check("R10 unmasked alert low", {15'd0, alert_n}, 16'd0);
    wr(4'hF, 16'h0);

    // R11 live power-good
    pwr_good = 1'b0;
    rd(4'h0, v); check("R11 main pg bad", v, 16'h0010);

    // R13 limit saturation
    wr(4'h7, 16'h0400);
    rd(4'h7, v); check("R13 limit clamp", v, 16'd511);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule